// File: doc/BRIEF.md
# Peak-Limited PWM Switch Controller

This block drives the power switch of a discontinuous-mode buck-boost converter from a chopper clock that arrives from outside its clock domain. Each chopper period the switch turns on when the chopper clock falls. It turns off at the earliest of three events: an internal digital ramp passing a sampled error word, the chopper clock going high again, or an over-current trip that has been latched. Because the chopper clock is low for most of its period (about 90% of roughly 85.3 kHz), the rising edge sets the upper limit on duty cycle.

The error word is the digital form of the integrated feedback voltage. It is captured once at the start of each cycle. The current-limit input comes from an outside comparator. During the first part of every on-time it is masked by a leading-edge blanking window, so that a reverse-recovery spike cannot end the pulse. A two-bit status output records why the last on-time ended.

Top module: `pwm_peak_ctrl`

## Requirements
- R1: A high-to-low transition on `chop_clk_i` starts a cycle. After two synchronizer flops and one edge register, `sw_on_o` goes high on the third rising edge of `clk` after the input changes. The ramp restarts from zero and the trip latch is cleared.
- R2: The ramp counts up by one on every `clk` cycle of on-time, starting from 0. The switch turns off on the edge after the ramp value becomes greater than the sampled error word, so the on-time is `err+2` cycles.
- R3: While the synchronized chopper clock is high, the switch turns off one cycle later and does not turn on. If `chop_clk_i` goes high L cycles after it fell, the on-time is at most L cycles. A chopper clock that stays high keeps the switch off.
- R4: When the synchronized current-limit input is high after blanking, the trip latch is set and the switch turns off on the next edge. It stays off until the chopper clock goes high.
- R5: The current-limit input is ignored for the first `BLANK_CYC` cycles of each on-time. A trip held from the start of the cycle gives an on-time of `BLANK_CYC+1` cycles. A pulse whose last high input cycle falls at or before on-time index `BLANK_CYC` has no effect.
- R6: `err_i` is sampled in the cycle in which the falling edge is detected. Changes to it later in the cycle do not change the on-time.
- R7: Once the switch turns off within a cycle, it stays off until the next detected falling edge.
- R8: The ramp saturates at its all-ones value. Reaching saturation ends the on-time, so a chopper clock stuck low gives at most `2**RAMP_W` cycles of on-time and no later pulse.
- R9: `end_cause_o` holds the cause of the last turn-off: 01 ramp, 10 chopper clock, 11 current limit. If several causes end the on-time on the same edge, current limit wins over ramp, and ramp wins over clock.
- R10: An active-low asynchronous reset forces `sw_on_o` to 0 and `end_cause_o` to 00 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chop_clk_i | input | 1 | External chopper clock, asynchronous |
| err_i | input | RAMP_W | Error word compared against the ramp |
| ilim_i | input | 1 | Current-limit comparator output, asynchronous |
| sw_on_o | output | 1 | Power switch enable |
| end_cause_o | output | 2 | Cause of the last turn-off |

## Verification
The bench sweeps every error word, every chopper low length up to beyond ramp saturation, and every current-trip arrival time in a small configuration. It compares the measured on-time and cause against a minimum of three arithmetic limits. An off-by-one in the ramp compare or the blanking count shows up as on-times one cycle long or short. A wrong priority shows up as the wrong cause on the ilim/ramp and ramp/clock tie cases. A blanking pulse that ends exactly at the boundary is checked alongside one that ends one cycle later, so a mask that is one cycle too short trips early. Separate cases cover a stuck-high clock, a stuck-low clock, an error word that changes mid-cycle, and reset during an on-time. These catch a design that turns on under a stuck-high clock, retriggers after a stuck-low timeout, or follows the live error word.

// File: rtl/pwm_peak_pkg.sv
package pwm_peak_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_RAMP = 2'b01,
    CAUSE_CLK  = 2'b10,
    CAUSE_ILIM = 2'b11
  } end_cause_e;
endpackage

// File: rtl/pwm_sync2.sv
module pwm_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int RAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  output logic [RAMP_W-1:0] val_o,
  output logic              at_max_o
);
  localparam logic [RAMP_W-1:0] RMAX = {RAMP_W{1'b1}};

  logic [RAMP_W-1:0] cnt_q, cnt_d;
  logic              cnt_we;

  always_comb begin
    cnt_we = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_we = 1'b1;
      cnt_d  = '0;
    end else if (en_i && (cnt_q != RMAX)) begin
      cnt_we = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign val_o    = cnt_q;
  assign at_max_o = (cnt_q == RMAX);

  p_ramp_hold_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max_o && !clr_i) |=> at_max_o);
  p_ramp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && !at_max_o) |=> (val_o == $past(val_o) + 1'b1));
endmodule

// File: rtl/pwm_blank.sv
module pwm_blank #(
  parameter int BLANK_CYC = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic en_i,
  output logic done_o
);
  localparam int BW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] LOADV = BW'(BLANK_CYC);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          cnt_we;

  always_comb begin
    cnt_we = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_we = 1'b1;
      cnt_d  = LOADV;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_we = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  p_blank_stays_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/pwm_peak_ctrl.sv
module pwm_peak_ctrl
  import pwm_peak_pkg::*;
#(
  parameter int RAMP_W    = 8,
  parameter int BLANK_CYC = 38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chop_clk_i,
  input  logic [RAMP_W-1:0] err_i,
  input  logic              ilim_i,
  output logic              sw_on_o,
  output logic [1:0]        end_cause_o
);
  logic [1:0]        sync_in, sync_out;
  logic              chop_s, ilim_s, chop_d_q;
  logic              fall;
  logic [RAMP_W-1:0] ramp_val;
  logic              ramp_max, blank_done;
  logic              on_q, on_d;
  logic              latch_q, latch_d;
  logic [RAMP_W-1:0] err_q, err_d;
  end_cause_e        cause_q, cause_d;
  logic              ramp_end, clk_end, ilim_end, any_end;

  assign sync_in = {ilim_i, chop_clk_i};

  pwm_sync2 #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sync_in), .q_o(sync_out)
  );
  assign chop_s = sync_out[0];
  assign ilim_s = sync_out[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chop_d_q <= 1'b0;
    else        chop_d_q <= chop_s;
  end
  assign fall = chop_d_q & ~chop_s;

  pwm_ramp #(.RAMP_W(RAMP_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr_i(fall), .en_i(on_q),
    .val_o(ramp_val), .at_max_o(ramp_max)
  );

  pwm_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .load_i(fall), .en_i(on_q),
    .done_o(blank_done)
  );

  assign ramp_end = on_q && ((ramp_val > err_q) || ramp_max);
  assign clk_end  = on_q && chop_s;
  assign ilim_end = on_q && ilim_s && blank_done;
  assign any_end  = ramp_end | clk_end | ilim_end | latch_q;

  always_comb begin
    on_d    = on_q;
    latch_d = latch_q;
    err_d   = err_q;
    cause_d = cause_q;
    if (fall) begin
      on_d    = 1'b1;
      latch_d = 1'b0;
      err_d   = err_i;
    end else begin
      if (chop_s) latch_d = 1'b0;
      if (ilim_end) latch_d = 1'b1;
      if (on_q && any_end) begin
        on_d = 1'b0;
        if (ilim_end)      cause_d = CAUSE_ILIM;
        else if (ramp_end) cause_d = CAUSE_RAMP;
        else if (clk_end)  cause_d = CAUSE_CLK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      latch_q <= 1'b0;
      err_q   <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      on_q    <= on_d;
      latch_q <= latch_d;
      cause_q <= cause_d;
      if (fall) err_q <= err_d;
    end
  end

  assign sw_on_o     = on_q;
  assign end_cause_o = cause_q;

  p_fall_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (sw_on_o && (ramp_val == '0) && !latch_q));
  p_clk_high_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chop_s |=> !sw_on_o);
  p_trip_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !chop_s) |=> (latch_q && !sw_on_o));
  p_no_trip_in_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sw_on_o) && (end_cause_o == CAUSE_ILIM)) |-> $past(blank_done));
  p_stay_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_on_o && !fall) |=> !sw_on_o);
  p_sat_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_on_o && ramp_max && !fall) |=> !sw_on_o);
  p_cause_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_on_o) |-> (end_cause_o != CAUSE_NONE));
  p_ilim_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && ilim_s && blank_done && !fall) |=> (end_cause_o == CAUSE_ILIM));
endmodule

// File: tb/pwm_peak_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_peak_ctrl_tb_top;
  localparam int RW = 5;
  localparam int BL = 4;
  localparam int M  = (1 << RW) - 1;
  localparam int H  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chop;
  logic [RW-1:0] err;
  logic          ilim;
  logic          sw_on;
  logic [1:0]    cause;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pwm_peak_ctrl #(.RAMP_W(RW), .BLANK_CYC(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .chop_clk_i(chop), .err_i(err),
    .ilim_i(ilim), .sw_on_o(sw_on), .end_cause_o(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One chopper period: low for lo cycles then high for H.
  task automatic period(input int lo, input int e0, input int e1,
                        input int ci, input int ce,
                        output int on, output int cs);
    on = 0;
    for (int c = 0; c < lo + H; c++) begin
      @(negedge clk);
      chop = (c >= lo);
      err  = (c < 3) ? RW'(e0) : RW'(e1);
      ilim = (c >= ci) && (c < ce);
      if (sw_on) on++;
    end
    @(negedge clk);
    cs = int'(cause);
  endtask

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic expect_run(input string req, input int lo, input int e,
                            input int ci);
    int on, cs, r, it, eo, ec;
    period(lo, e, e, (ci < 0) ? 1000 : ci, 1000, on, cs);
    r  = mn(e + 2, M + 1);
    it = (ci < 0) ? 1000 : ((ci > BL + 1) ? ci : BL + 1);
    eo = mn(mn(r, lo), it);
    ec = (it == eo) ? 3 : ((r == eo) ? 1 : 2);
    chk({req, " on-time"}, on, eo);
    chk({req, " cause"}, cs, ec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int on, cs;
    rst_n = 1'b0; chop = 1'b1; err = '0; ilim = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 reset sw", int'(sw_on), 0);
    chk("R10 reset cause", int'(cause), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R3: stuck-high chopper clock never turns the switch on
    on = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (sw_on) on++;
    end
    chk("R3 stuck high", on, 0);

    // R2 and R1: sweep every error word with a long low phase
    for (int e = 0; e <= M; e++) expect_run("R2", 40, e, -1);

    // R3 and R9: sweep low length against a full-scale error word
    for (int lo = 2; lo <= 40; lo++) expect_run("R3", lo, M, -1);

    // R9: ramp and clock end on the same edge -> ramp cause
    expect_run("R9 ramp-clk tie", 12, 10, -1);

    // R4 and R5: sweep the trip arrival time
    for (int ci = 0; ci <= 20; ci++) expect_run("R4", 40, M, ci);

    // R9: trip and ramp on the same edge -> current limit cause
    expect_run("R9 ilim-ramp tie", 40, 8, 10);

    // R5: pulse ending at the blanking edge is ignored
    period(40, 10, 10, 0, BL + 1, on, cs);
    chk("R5 masked pulse on-time", on, 12);
    chk("R5 masked pulse cause", cs, 1);
    // R5: pulse one cycle longer trips
    period(40, 10, 10, 0, BL + 2, on, cs);
    chk("R5 late pulse on-time", on, BL + 1);
    chk("R5 late pulse cause", cs, 3);

    // R6: error word changed after the cycle start has no effect
    period(40, 6, 25, 1000, 1000, on, cs);
    chk("R6 sampled err", on, 8);
    period(40, 25, 2, 1000, 1000, on, cs);
    chk("R6 sampled err hi", on, 27);

    // R8 and R7: stuck-low clock, saturation ends on-time, no retrigger
    period(200, M, M, 1000, 1000, on, cs);
    chk("R8 stuck low on-time", on, M + 1);
    chk("R8 stuck low cause", cs, 1);

    // R7: trip during a long low phase keeps switch off afterwards
    period(60, M, M, 7, 1000, on, cs);
    chk("R7 stays off after trip", on, 7);

    // R10: reset during an on-time drops the switch at once
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chop = (c < 5) ? 1'b0 : 1'b1;
      err  = RW'(M);
      ilim = 1'b0;
    end
    chop = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 pre-reset on", int'(sw_on), 1);
    rst_n = 1'b0;
    #1;
    chk("R10 async off", int'(sw_on), 0);
    chk("R10 async cause", int'(cause), 0);
    @(negedge clk);
    rst_n = 1'b1;
    chop = 1'b1;
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule